// File: doc/BRIEF.md
# Cache Line Flush Controller

This block manages the line-state array of a small write-back data cache. It executes maintenance commands that software issues through a control/status write. Every line holds a valid bit, a modified bit, a lock bit, a tag and one data word. A flush command names one line by its index. If the line is valid, modified and unlocked, the controller moves the line into a copyback buffer and clears the line in the same clock edge. It then writes the buffer to memory over a valid/ready request channel and waits for a response that can carry an error flag. A clean line is only invalidated. A locked line and an invalid line are not touched.

If the response reports an error, a sticky error bit is set and a one-cycle machine-check pulse is raised. The data that failed to write stays readable in the copyback buffer, and the line has already left the array. The block also executes two more commands: an invalidate of the whole array in one edge, and a lock-aware invalidate of a single line that checks the tag. A fill port lets the surrounding cache install lines. A read port shows the state of any line.

Top module: `cache_flush_ctrl`

## Requirements
- R1: A flush command (code 4'b1110) on a line that is valid, modified and unlocked copies the line's data and its address {tag, index} into the copyback buffer. In the same edge it clears the line's valid and modified bits. The next cycle, mem_req_valid rises with the buffer contents as payload.
- R2: A flush command on a line that is valid, unmodified and unlocked clears the line's valid bit. It makes no memory request and never asserts busy.
- R3: A flush command on a locked line or on an invalid line changes no line state and makes no memory request.
- R4: The request channel follows valid/ready rules. The request is transferred on an edge where mem_req_valid and mem_req_ready are both high. While mem_req_ready is low, mem_req_valid stays high and the address and data stay stable.
- R5: busy is high from the edge that accepts a writing flush until the edge that takes the memory response. Any command written while busy is high is ignored.
- R6: A response with mem_rsp_err high sets err_sticky and raises mchk for exactly one cycle, the cycle after the response. The copyback buffer keeps the failed data.
- R7: err_sticky is cleared only by a control write with csr_clr_err = 1. A control write with csr_clr_err = 0 leaves it set. If an error response and a clear arrive in the same cycle, the error wins.
- R8: The invalidate-all command (code 4'b0110) clears the valid and modified bits of every line in one edge. Lock bits, tags and data are kept.
- R9: The single-line invalidate command (code 4'b0010) clears the valid and modified bits of the indexed line only if the line is valid, unlocked and its tag equals csr_tag. Otherwise it does nothing.
- R10: After reset every line is invalid, unmodified and unlocked. busy, err_sticky, mchk and mem_req_valid are low.
- R11: A control write with any other command code changes no line state and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Control/status write strobe |
| csr_cmd | input | 4 | Command code |
| csr_clr_err | input | 1 | Write 1 to clear err_sticky |
| csr_idx | input | IDX_W | Line index for the command |
| csr_tag | input | TAG_W | Tag compared by the single-line invalidate |
| fill_en | input | 1 | Install a line |
| fill_idx | input | IDX_W | Line to install |
| fill_tag | input | TAG_W | Tag to install |
| fill_data | input | DATA_W | Data to install |
| fill_valid | input | 1 | Valid bit to install |
| fill_dirty | input | 1 | Modified bit to install |
| fill_lock | input | 1 | Lock bit to install |
| rd_idx | input | IDX_W | Line shown on the rd_* outputs |
| rd_valid | output | 1 | Valid bit of the shown line |
| rd_dirty | output | 1 | Modified bit of the shown line |
| rd_lock | output | 1 | Lock bit of the shown line |
| rd_tag | output | TAG_W | Tag of the shown line |
| rd_data | output | DATA_W | Data of the shown line |
| busy | output | 1 | A writeback is in progress |
| err_sticky | output | 1 | Sticky bus-error status |
| mchk | output | 1 | Machine-check pulse |
| cb_addr | output | TAG_W+IDX_W | Copyback buffer address |
| cb_data | output | DATA_W | Copyback buffer data |
| mem_req_valid | output | 1 | Write request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | TAG_W+IDX_W | Write line address |
| mem_req_data | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Response carries an error |

## Verification
Flush is tried on lines in each of four states: modified, clean, locked and invalid. This shows that only the modified, unlocked case reaches the bus and that the clean case only invalidates. The writing flush is run once with the ready signal held back for several cycles and once with immediate acceptance plus an error response. The first run shows back-pressure holding and a second command being refused while busy. The second run shows the sticky flag, the one-cycle machine-check and the data kept in the buffer. The single-line invalidate is given a tag mismatch, a locked hit and a true hit, and the invalidate-all is run on a mixed array to show that lock bits survive it.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam logic [3:0] CMD_FLUSH    = 4'b1110;
  localparam logic [3:0] CMD_INV_ALL  = 4'b0110;
  localparam logic [3:0] CMD_INV_LINE = 4'b0010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } cfl_state_e;
endpackage

// File: rtl/cfl_line_store.sv
module cfl_line_store #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_valid,
  input  logic              fill_dirty,
  input  logic              fill_lock,
  input  logic              clr_one,
  input  logic              clr_all,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic              cmd_valid,
  output logic              cmd_dirty,
  output logic              cmd_lock,
  output logic [TAG_W-1:0]  cmd_tag,
  output logic [DATA_W-1:0] cmd_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic              rd_lock,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  dty_q;
  logic [LINES-1:0]  lck_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      lck_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld_q[fill_idx] <= fill_valid;
        dty_q[fill_idx] <= fill_dirty;
        lck_q[fill_idx] <= fill_lock;
        tag_q[fill_idx] <= fill_tag;
        dat_q[fill_idx] <= fill_data;
      end
      if (clr_all) begin
        vld_q <= '0;
        dty_q <= '0;
      end
      if (clr_one) begin
        vld_q[cmd_idx] <= 1'b0;
        dty_q[cmd_idx] <= 1'b0;
      end
    end
  end

  assign cmd_valid = vld_q[cmd_idx];
  assign cmd_dirty = dty_q[cmd_idx];
  assign cmd_lock  = lck_q[cmd_idx];
  assign cmd_tag   = tag_q[cmd_idx];
  assign cmd_data  = dat_q[cmd_idx];

  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = dty_q[rd_idx];
  assign rd_lock  = lck_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];
endmodule

// File: rtl/cfl_copyback.sv
module cfl_copyback #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr <= '0;
      buf_data <= '0;
    end else if (load) begin
      buf_addr <= in_addr;
      buf_data <= in_data;
    end
  end
endmodule

// File: rtl/cfl_seq.sv
module cfl_seq
  import cfl_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [3:0]       csr_cmd,
  input  logic             csr_clr_err,
  input  logic [TAG_W-1:0] csr_tag,
  input  logic             line_valid,
  input  logic             line_dirty,
  input  logic             line_lock,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  output logic             clr_one,
  output logic             clr_all,
  output logic             cb_load,
  output logic             busy,
  output logic             req_valid,
  output logic             err_sticky,
  output logic             mchk
);
  cfl_state_e state_q, state_n;
  logic accept, open_line, do_flush, do_inv_line, rsp_take, err_n;

  assign accept      = csr_wr && (state_q == ST_IDLE);
  assign open_line   = line_valid && !line_lock;
  assign do_flush    = accept && (csr_cmd == CMD_FLUSH) && open_line;
  assign do_inv_line = accept && (csr_cmd == CMD_INV_LINE) && open_line
                       && (line_tag == csr_tag);
  assign rsp_take    = (state_q == ST_WAIT) && mem_rsp_valid;

  assign cb_load = do_flush && line_dirty;
  assign clr_one = do_flush || do_inv_line;
  assign clr_all = accept && (csr_cmd == CMD_INV_ALL);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (cb_load) state_n = ST_REQ;
      ST_REQ:  if (mem_req_ready) state_n = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    err_n = err_sticky;
    if (csr_wr && csr_clr_err) err_n = 1'b0;
    if (rsp_take && mem_rsp_err) err_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      err_sticky <= 1'b0;
      mchk       <= 1'b0;
    end else begin
      state_q    <= state_n;
      err_sticky <= err_n;
      mchk       <= rsp_take && mem_rsp_err;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
endmodule

// File: rtl/cache_flush_ctrl.sv
module cache_flush_ctrl #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [3:0]        csr_cmd,
  input  logic              csr_clr_err,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [TAG_W-1:0]  csr_tag,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_valid,
  input  logic              fill_dirty,
  input  logic              fill_lock,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic              rd_lock,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              err_sticky,
  output logic              mchk,
  output logic [ADDR_W-1:0] cb_addr,
  output logic [DATA_W-1:0] cb_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err
);
  logic              clr_one, clr_all, cb_load;
  logic              ln_valid, ln_dirty, ln_lock;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;

  cfl_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
    .fill_valid(fill_valid), .fill_dirty(fill_dirty), .fill_lock(fill_lock),
    .clr_one(clr_one), .clr_all(clr_all), .cmd_idx(csr_idx),
    .cmd_valid(ln_valid), .cmd_dirty(ln_dirty), .cmd_lock(ln_lock),
    .cmd_tag(ln_tag), .cmd_data(ln_data),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_lock(rd_lock),
    .rd_tag(rd_tag), .rd_data(rd_data)
  );

  cfl_copyback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cb (
    .clk(clk), .rst_n(rst_n), .load(cb_load),
    .in_addr({ln_tag, csr_idx}), .in_data(ln_data),
    .buf_addr(cb_addr), .buf_data(cb_data)
  );

  cfl_seq #(.TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_cmd(csr_cmd), .csr_clr_err(csr_clr_err), .csr_tag(csr_tag),
    .line_valid(ln_valid), .line_dirty(ln_dirty), .line_lock(ln_lock), .line_tag(ln_tag),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .clr_one(clr_one), .clr_all(clr_all), .cb_load(cb_load),
    .busy(busy), .req_valid(mem_req_valid), .err_sticky(err_sticky), .mchk(mchk)
  );

  assign mem_req_addr = cb_addr;
  assign mem_req_data = cb_data;
endmodule

// File: rtl/cache_flush_ctrl_chk.sv
module cache_flush_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr,
  input logic [3:0]        csr_cmd,
  input logic              csr_clr_err,
  input logic              busy,
  input logic              err_sticky,
  input logic              mchk,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_data
);
  // R4: a stalled request keeps its valid and payload
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

  // R5: a request is only outstanding while busy
  a_r5_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R1: a request starts only after a flush write
  a_r1_req_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(csr_wr && csr_cmd == 4'b1110));

  // R6: machine-check lasts one cycle and comes with the sticky flag
  a_r6_mchk_single: assert property (@(posedge clk) disable iff (!rst_n)
    mchk |=> !mchk);
  a_r6_mchk_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mchk |-> err_sticky);

  // R7: the sticky flag only drops after a clear write
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_sticky) |-> $past(csr_wr && csr_clr_err));
endmodule

bind cache_flush_ctrl cache_flush_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_cmd(csr_cmd), .csr_clr_err(csr_clr_err),
  .busy(busy), .err_sticky(err_sticky), .mchk(mchk),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data)
);

// File: tb/cache_flush_ctrl_test.sv
module cache_flush_ctrl_test;
  localparam int LINES = 8, TAG_W = 8, DATA_W = 32, IDX_W = 3, ADDR_W = TAG_W + IDX_W;
  localparam logic [3:0] FLUSH = 4'b1110, INV_ALL = 4'b0110, INV_LINE = 4'b0010;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic csr_wr = 0, csr_clr_err = 0;
  logic [3:0] csr_cmd = '0;
  logic [IDX_W-1:0] csr_idx = '0, fill_idx = '0, rd_idx = '0;
  logic [TAG_W-1:0] csr_tag = '0, fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic fill_en = 0, fill_valid = 0, fill_dirty = 0, fill_lock = 0;
  logic rd_valid, rd_dirty, rd_lock, busy, err_sticky, mchk, mem_req_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [DATA_W-1:0] rd_data, cb_data, mem_req_data;
  logic [ADDR_W-1:0] cb_addr, mem_req_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_err = 0;

  cache_flush_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_cmd(csr_cmd), .csr_clr_err(csr_clr_err),
    .csr_idx(csr_idx), .csr_tag(csr_tag), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_data(fill_data), .fill_valid(fill_valid),
    .fill_dirty(fill_dirty), .fill_lock(fill_lock), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_dirty(rd_dirty), .rd_lock(rd_lock), .rd_tag(rd_tag), .rd_data(rd_data),
    .busy(busy), .err_sticky(err_sticky), .mchk(mchk), .cb_addr(cb_addr), .cb_data(cb_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_v[LINES], m_d[LINES], m_l[LINES];
  logic [TAG_W-1:0] m_tag[LINES];
  logic [DATA_W-1:0] m_dat[LINES];
  int m_st = 0;
  bit m_err = 0, m_mchk = 0;
  logic [ADDR_W-1:0] m_cba = '0;
  logic [DATA_W-1:0] m_cbd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        m_v[i] = 0; m_d[i] = 0; m_l[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
      end
      m_st = 0; m_err = 0; m_mchk = 0; m_cba = '0; m_cbd = '0;
    end else begin
      int nst;
      bit err_new;
      nst = m_st;
      err_new = 0;
      if (m_st == 1 && mem_req_ready) nst = 2;
      if (m_st == 2 && mem_rsp_valid) begin
        nst = 0;
        err_new = mem_rsp_err;
      end
      if (csr_wr && m_st == 0) begin
        int k;
        k = int'(csr_idx);
        if (csr_cmd == FLUSH && m_v[k] && !m_l[k]) begin
          if (m_d[k]) begin
            m_cba = {m_tag[k], csr_idx};
            m_cbd = m_dat[k];
            nst = 1;
          end
          m_v[k] = 0; m_d[k] = 0;
        end else if (csr_cmd == INV_LINE && m_v[k] && !m_l[k] && m_tag[k] == csr_tag) begin
          m_v[k] = 0; m_d[k] = 0;
        end else if (csr_cmd == INV_ALL) begin
          for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_d[i] = 0; end
        end
      end
      if (fill_en) begin
        m_v[fill_idx] = fill_valid; m_d[fill_idx] = fill_dirty; m_l[fill_idx] = fill_lock;
        m_tag[fill_idx] = fill_tag; m_dat[fill_idx] = fill_data;
      end
      if (csr_wr && csr_clr_err) m_err = 0;
      if (err_new) m_err = 1;
      m_mchk = err_new;
      m_st = nst;
    end
  end

  // Per-cycle comparison against the model
  int mchk_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5", "busy", busy, m_st != 0);
      chk("R4", "mem_req_valid", mem_req_valid, m_st == 1);
      chk("R6", "err_sticky", err_sticky, m_err);
      chk("R6", "mchk", mchk, m_mchk);
      chk("R1", "cb_addr", cb_addr, m_cba);
      chk("R1", "cb_data", cb_data, m_cbd);
      if (mem_req_valid) begin
        chk("R4", "req_addr", mem_req_addr, m_cba);
        chk("R4", "req_data", mem_req_data, m_cbd);
      end
      if (mchk) mchk_seen++;
    end
  end

  // Memory responder
  int ready_delay = 0, wcnt = 0, hs_count = 0;
  bit err_mode = 0, hs = 0;
  always @(negedge clk) begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0;
    if (hs) begin
      mem_rsp_valid = 1; mem_rsp_err = err_mode; hs = 0;
    end else if (mem_req_valid) begin
      if (wcnt >= ready_delay) begin
        mem_req_ready = 1; wcnt = 0; hs = 1; hs_count++;
      end else wcnt++;
    end
  end

  task automatic cmd(logic [3:0] c, int idx, logic [TAG_W-1:0] t, bit clr);
    @(negedge clk);
    csr_wr = 1; csr_cmd = c; csr_idx = IDX_W'(idx); csr_tag = t; csr_clr_err = clr;
    @(negedge clk);
    csr_wr = 0; csr_clr_err = 0;
  endtask

  task automatic fill(int idx, logic [TAG_W-1:0] t, logic [DATA_W-1:0] d, bit v, bit dt, bit l);
    @(negedge clk);
    fill_en = 1; fill_idx = IDX_W'(idx); fill_tag = t; fill_data = d;
    fill_valid = v; fill_dirty = dt; fill_lock = l;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic line_chk(string req, int idx);
    rd_idx = IDX_W'(idx);
    #1;
    chk(req, $sformatf("line%0d valid", idx), rd_valid, m_v[idx]);
    chk(req, $sformatf("line%0d dirty", idx), rd_dirty, m_d[idx]);
    chk(req, $sformatf("line%0d lock", idx), rd_lock, m_l[idx]);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 50 && busy; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int hs0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    for (int i = 0; i < LINES; i++) begin
      rd_idx = IDX_W'(i); #1;
      chk("R10", "reset valid", rd_valid, 0);
      chk("R10", "reset lock", rd_lock, 0);
    end
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset err", err_sticky, 0);

    fill(0, 8'h11, 32'hA0A0_0001, 1, 1, 0);
    fill(1, 8'h22, 32'hB0B0_0002, 1, 0, 0);
    fill(2, 8'h33, 32'hC0C0_0003, 1, 1, 1);
    fill(3, 8'h44, 32'hD0D0_0004, 0, 1, 0);
    fill(4, 8'h55, 32'hE0E0_0005, 1, 1, 0);
    fill(5, 8'h66, 32'hF0F0_0006, 1, 0, 0);
    fill(6, 8'h77, 32'h1234_5678, 1, 0, 1);

    // R1/R4/R5: dirty flush with back-pressure, second command refused
    ready_delay = 3;
    cmd(FLUSH, 0, '0, 0);
    line_chk("R1", 0);
    chk("R1", "cb_data after flush", cb_data, 32'hA0A0_0001);
    chk("R1", "cb_addr after flush", cb_addr, {8'h11, 3'd0});
    chk("R5", "busy after accept", busy, 1);
    cmd(FLUSH, 4, '0, 0);
    line_chk("R5", 4);
    chk("R5", "line4 kept while busy", rd_valid, 1);
    wait_idle();
    chk("R1", "one bus write", hs_count, 1);

    // R2: clean flush
    hs0 = hs_count;
    cmd(FLUSH, 1, '0, 0);
    line_chk("R2", 1);
    chk("R2", "clean invalidated", rd_valid, 0);
    chk("R2", "clean no busy", busy, 0);
    chk("R2", "clean no write", hs_count, hs0);

    // R3: locked and invalid lines
    cmd(FLUSH, 2, '0, 0);
    cmd(FLUSH, 3, '0, 0);
    repeat (3) @(negedge clk);
    line_chk("R3", 2);
    chk("R3", "locked kept", rd_valid, 1);
    line_chk("R3", 3);
    chk("R3", "no write", hs_count, hs0);

    // R6: bus error
    ready_delay = 0; err_mode = 1;
    cmd(FLUSH, 4, '0, 0);
    line_chk("R6", 4);
    chk("R6", "line4 gone before response", rd_valid, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    err_mode = 0;
    chk("R6", "err set", err_sticky, 1);
    chk("R6", "mchk pulses", mchk_seen, 1);
    chk("R6", "buffer keeps data", cb_data, 32'hE0E0_0005);

    // R7: clear only by writing 1; R11 unknown code
    cmd(4'b0000, 0, '0, 0);
    chk("R7", "err kept on write 0", err_sticky, 1);
    cmd(4'b0000, 0, '0, 1);
    chk("R7", "err cleared", err_sticky, 0);
    cmd(4'b0011, 5, 8'h66, 0);
    line_chk("R11", 5);
    chk("R11", "unknown code ignored", rd_valid, 1);

    // R9: single-line invalidate
    cmd(INV_LINE, 5, 8'h65, 0);
    line_chk("R9", 5);
    chk("R9", "tag mismatch kept", rd_valid, 1);
    cmd(INV_LINE, 6, 8'h77, 0);
    line_chk("R9", 6);
    chk("R9", "locked hit kept", rd_valid, 1);
    cmd(INV_LINE, 5, 8'h66, 0);
    line_chk("R9", 5);
    chk("R9", "hit cleared", rd_valid, 0);

    // R8: invalidate all
    fill(0, 8'h19, 32'h0BAD_0000, 1, 1, 0);
    cmd(INV_ALL, 0, '0, 0);
    for (int i = 0; i < LINES; i++) line_chk("R8", i);
    rd_idx = 3'd2; #1;
    chk("R8", "lock kept", rd_lock, 1);
    chk("R8", "tag kept", rd_tag, 8'h33);
    chk("R8", "no write", hs_count, hs0 + 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule